// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor with Checkpoint Restore

This block predicts whether a conditional branch will be taken. It holds a table of 2-bit saturating counters, and the table is indexed by the low bits of the branch address. The block keeps two copies of this table. The speculative copy serves the fetch lookups and takes the updates that fetch makes as it predicts. The architectural copy changes only when branches retire, so it always matches the committed path.

When the pipeline flushes after an exception or a mispredicted branch, all of the speculative copy is reloaded from the architectural copy in one cycle. Any history left by squashed branches is discarded that way. Two lookups, one speculative update and two retire updates are served in every cycle.

Top module: `bimodal_ckpt_predictor`

## Requirements
- R1: The table has 32 entries, indexed by PC bits [4:0]. After reset, every counter in both copies holds 01 (weakly not-taken), so a single taken update makes that entry predict taken.
- R2: A lookup predicts taken (lk_taken_o bit = 1) when its counter is 2 or 3, and not-taken when it is 0 or 1.
- R3: A speculative update with taken=1 increments the counter and stops at 3. One with taken=0 decrements it and stops at 0. The new value is visible to lookups from the next cycle.
- R4: Both lookup ports are served in the same cycle, independently. Each one reads the counter as it stood before the update of that cycle.
- R5: Retire updates change only the architectural copy. Speculative predictions do not move until a flush.
- R6: Speculative updates never change the architectural copy. After a flush, the speculative history is gone.
- R7: When both retire ports hit the same index in one cycle, both steps are applied, port 0 first and then port 1.
- R8: On a flush, every speculative counter takes the architectural value, including the retire updates of that same cycle. A speculative update in the flush cycle is discarded.
- R9: During a flush cycle, lookups return the architectural prediction as it stood at the start of that cycle.
- R10: PC bits above bit 4 are ignored, so addresses that share bits [4:0] alias to the same counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_pc_i | input | 2x32 | Fetch lookup PCs, one per port |
| lk_taken_o | output | 2 | Taken prediction, one per lookup port |
| su_valid_i | input | 1 | Speculative update enable |
| su_pc_i | input | 32 | Speculative update PC |
| su_taken_i | input | 1 | Speculative update direction |
| rt_valid_i | input | 2 | Retire update enables, port 0 older |
| rt_pc_i | input | 2x32 | Retire update PCs |
| rt_taken_i | input | 2 | Retire resolved directions |
| flush_i | input | 1 | Restore the speculative copy from the architectural copy |

## Verification
A flush can fall in the same cycle as retire updates, a speculative update and lookups. The restore must then carry the retire updates of that cycle, drop the speculative update, and feed the lookups the architectural values from the start of the cycle. The stimulus sends flushes together with retire updates on the same index and with speculative updates. It also sends both retire ports to one index with opposite directions near saturation, where the order of application changes the result. A behavioural model of the two tables judges every lookup on every cycle, and that includes the flush cycles.

// File: rtl/bimodal_pkg.sv
package bimodal_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_RESET = 2'b01;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == 2'd3) ? c : c + 2'd1;
    else       return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_arch_table.sv
module bp_arch_table
  import bimodal_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int NUM_RET = 2,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_RET-1:0]             ret_valid_i,
  input  logic [NUM_RET-1:0][IDX_W-1:0]  ret_idx_i,
  input  logic [NUM_RET-1:0]             ret_taken_i,
  output ctr_t [ENTRIES-1:0]             table_o,
  output ctr_t [ENTRIES-1:0]             table_next_o
);
  ctr_t [ENTRIES-1:0] table_q, table_d;

  // ports applied oldest first
  always_comb begin
    table_d = table_q;
    for (int p = 0; p < NUM_RET; p++) begin
      if (ret_valid_i[p])
        table_d[ret_idx_i[p]] = ctr_step(table_d[ret_idx_i[p]], ret_taken_i[p]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) table_q <= {ENTRIES{CTR_RESET}};
    else         table_q <= table_d;
  end

  assign table_o      = table_q;
  assign table_next_o = table_d;

  assert_arch_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|ret_valid_i) |=> $stable(table_q));
endmodule

// File: rtl/bp_spec_table.sv
module bp_spec_table
  import bimodal_pkg::*;
#(
  parameter int IDX_W = 5,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  ctr_t [ENTRIES-1:0]  restore_i,
  input  logic                upd_valid_i,
  input  logic [IDX_W-1:0]    upd_idx_i,
  input  logic                upd_taken_i,
  output ctr_t [ENTRIES-1:0]  table_o
);
  ctr_t [ENTRIES-1:0] table_q, table_d;

  always_comb begin
    table_d = table_q;
    if (flush_i)
      table_d = restore_i;
    else if (upd_valid_i)
      table_d[upd_idx_i] = ctr_step(table_q[upd_idx_i], upd_taken_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) table_q <= {ENTRIES{CTR_RESET}};
    else         table_q <= table_d;
  end

  assign table_o = table_q;

  assert_spec_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_valid_i && !flush_i) |=> $stable(table_q));

  assert_sat_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !flush_i && upd_taken_i && table_q[upd_idx_i] == 2'd3)
    |=> table_q[$past(upd_idx_i)] == 2'd3);

  assert_sat_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !flush_i && !upd_taken_i && table_q[upd_idx_i] == 2'd0)
    |=> table_q[$past(upd_idx_i)] == 2'd0);
endmodule

// File: rtl/bp_read_port.sv
module bp_read_port
  import bimodal_pkg::*;
#(
  parameter int IDX_W = 5,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                flush_i,
  input  ctr_t [ENTRIES-1:0]  spec_i,
  input  ctr_t [ENTRIES-1:0]  arch_i,
  output logic                taken_o
);
  ctr_t sel;
  assign sel     = flush_i ? arch_i[idx_i] : spec_i[idx_i];
  assign taken_o = sel[1];
endmodule

// File: rtl/bimodal_ckpt_predictor.sv
module bimodal_ckpt_predictor
  import bimodal_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 5,
  parameter int NUM_LK  = 2,
  parameter int NUM_RET = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_LK-1:0][PC_W-1:0]   lk_pc_i,
  output logic [NUM_LK-1:0]             lk_taken_o,
  input  logic                          su_valid_i,
  input  logic [PC_W-1:0]               su_pc_i,
  input  logic                          su_taken_i,
  input  logic [NUM_RET-1:0]            rt_valid_i,
  input  logic [NUM_RET-1:0][PC_W-1:0]  rt_pc_i,
  input  logic [NUM_RET-1:0]            rt_taken_i,
  input  logic                          flush_i
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_t [ENTRIES-1:0] spec_tbl, arch_tbl, arch_next;
  logic [NUM_RET-1:0][IDX_W-1:0] rt_idx;

  for (genvar p = 0; p < NUM_RET; p++) begin : g_rt_idx
    assign rt_idx[p] = rt_pc_i[p][IDX_W-1:0];
  end

  bp_arch_table #(.IDX_W(IDX_W), .NUM_RET(NUM_RET)) u_arch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ret_valid_i  (rt_valid_i),
    .ret_idx_i    (rt_idx),
    .ret_taken_i  (rt_taken_i),
    .table_o      (arch_tbl),
    .table_next_o (arch_next)
  );

  bp_spec_table #(.IDX_W(IDX_W)) u_spec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .restore_i   (arch_next),
    .upd_valid_i (su_valid_i),
    .upd_idx_i   (su_pc_i[IDX_W-1:0]),
    .upd_taken_i (su_taken_i),
    .table_o     (spec_tbl)
  );

  for (genvar l = 0; l < NUM_LK; l++) begin : g_lk
    bp_read_port #(.IDX_W(IDX_W)) u_rd (
      .idx_i   (lk_pc_i[l][IDX_W-1:0]),
      .flush_i (flush_i),
      .spec_i  (spec_tbl),
      .arch_i  (arch_tbl),
      .taken_o (lk_taken_o[l])
    );

    assert_flush_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |-> lk_taken_o[l] == arch_tbl[lk_pc_i[l][IDX_W-1:0]][1]);
  end

  assert_restore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> spec_tbl == arch_tbl);
endmodule

// File: tb/bimodal_ckpt_predictor_test.sv
`timescale 1ns/1ps
module bimodal_ckpt_predictor_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0][31:0] lk_pc;
  logic [1:0]       lk_taken;
  logic             su_valid, su_taken;
  logic [31:0]      su_pc;
  logic [1:0]       rt_valid, rt_taken;
  logic [1:0][31:0] rt_pc;
  logic             flush;

  int checks = 0, failures = 0;
  int spec_m[32];
  int arch_m[32];
  bit done = 0;

  always #4 clk = ~clk;

  bimodal_ckpt_predictor uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_pc_i(lk_pc), .lk_taken_o(lk_taken),
    .su_valid_i(su_valid), .su_pc_i(su_pc), .su_taken_i(su_taken),
    .rt_valid_i(rt_valid), .rt_pc_i(rt_pc), .rt_taken_i(rt_taken),
    .flush_i(flush)
  );

  function automatic int stp(int c, bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic step(input logic [31:0] l0, input logic [31:0] l1,
                      input bit sv, input logic [31:0] spc, input bit st,
                      input bit rv0, input logic [31:0] rp0, input bit rtk0,
                      input bit rv1, input logic [31:0] rp1, input bit rtk1,
                      input bit fl, input string tag);
    int tmp[32];
    @(negedge clk);
    lk_pc = {l1, l0};
    su_valid = sv; su_pc = spc; su_taken = st;
    rt_valid = {rv1, rv0}; rt_pc = {rp1, rp0}; rt_taken = {rtk1, rtk0};
    flush = fl;
    #2;
    for (int p = 0; p < 2; p++) begin
      int idx;
      bit exp;
      idx = int'(lk_pc[p][4:0]);
      exp = fl ? (arch_m[idx] >= 2) : (spec_m[idx] >= 2);
      checks++;
      if (lk_taken[p] !== exp) begin
        failures++;
        $display("FAIL %s%s port%0d idx%0d got %0b exp %0b",
                 tag, fl ? "/R9" : "", p, idx, lk_taken[p], exp);
      end
    end
    tmp = arch_m;
    if (rv0) tmp[rp0[4:0]] = stp(tmp[rp0[4:0]], rtk0);
    if (rv1) tmp[rp1[4:0]] = stp(tmp[rp1[4:0]], rtk1);
    if (fl) spec_m = tmp;
    else if (sv) spec_m[spc[4:0]] = stp(spec_m[spc[4:0]], st);
    arch_m = tmp;
  endtask

  task automatic look(input logic [31:0] a, input logic [31:0] b, input string tag);
    step(a, b, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic spec_upd(input logic [31:0] pc, input bit t, input string tag);
    step(pc, pc, 1, pc, t, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_flush(input logic [31:0] a, input string tag);
    step(a, a, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin spec_m[i] = 1; arch_m[i] = 1; end
    lk_pc = '0; su_valid = 0; su_pc = '0; su_taken = 0;
    rt_valid = '0; rt_pc = '0; rt_taken = '0; flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state, weakly not-taken
    for (int i = 0; i < 32; i += 2) look(i, i + 1, "R1");
    spec_upd(32'h5, 1, "R1");
    look(32'h5, 32'h6, "R1");
    // R3 saturation on the speculative side
    spec_upd(32'h5, 1, "R3");
    spec_upd(32'h5, 1, "R3");
    spec_upd(32'h5, 1, "R3");
    spec_upd(32'h5, 0, "R3");
    look(32'h5, 32'h5, "R3");
    spec_upd(32'h5, 0, "R3");
    look(32'h5, 32'h5, "R3");
    spec_upd(32'h3, 0, "R3");
    spec_upd(32'h3, 0, "R3");
    spec_upd(32'h3, 1, "R3");
    look(32'h3, 32'h3, "R2");
    spec_upd(32'h3, 1, "R2");
    look(32'h3, 32'h3, "R2");
    // R10 aliasing on upper PC bits
    spec_upd(32'h0000_1108, 1, "R10");
    look(32'h8, 32'hFFFF_FFE8, "R10");
    // R5 retire does not touch speculative copy
    step(32'h7, 32'h7, 0, 0, 0, 1, 32'h7, 1, 1, 32'h7, 1, 0, "R5");
    look(32'h7, 32'h27, "R5");
    do_flush(32'h7, "R8");
    look(32'h7, 32'h5, "R8");
    // R6 speculative updates lost at flush
    spec_upd(32'h9, 1, "R6");
    spec_upd(32'h9, 1, "R6");
    look(32'h9, 32'h9, "R6");
    do_flush(32'h9, "R6");
    look(32'h9, 32'h9, "R6");
    // R7 same-index retire order
    step(32'hB, 32'hB, 0, 0, 0, 1, 32'hB, 1, 1, 32'h2B, 1, 0, "R7");
    step(32'hB, 32'hB, 0, 0, 0, 1, 32'hB, 1, 1, 32'hB, 0, 0, "R7");
    do_flush(32'hB, "R7");
    look(32'hB, 32'hB, "R7");
    step(32'hC, 32'hC, 0, 0, 0, 1, 32'hC, 1, 1, 32'hC, 1, 0, "R7");
    step(32'hC, 32'hC, 0, 0, 0, 1, 32'hC, 0, 1, 32'hC, 1, 0, "R7");
    step(32'hC, 32'hC, 0, 0, 0, 1, 32'hC, 0, 1, 32'hC, 0, 0, "R7");
    do_flush(32'hC, "R7");
    look(32'hC, 32'hC, "R7");
    // R8 retire and speculative update in the flush cycle
    step(32'hD, 32'hE, 1, 32'hE, 1, 1, 32'hD, 1, 1, 32'hD, 1, 1, "R8");
    look(32'hD, 32'hE, "R8");
    // R4 mixed traffic with collisions on few indices
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b, s, r0, r1;
      a  = {$urandom() % 8, 5'(  $urandom_range(0, 5))};
      b  = {$urandom() % 8, 5'(  $urandom_range(0, 5))};
      s  = {$urandom() % 8, 5'(  $urandom_range(0, 5))};
      r0 = {$urandom() % 8, 5'(  $urandom_range(0, 5))};
      r1 = ($urandom() % 2) ? r0 : {$urandom() % 8, 5'($urandom_range(0, 5))};
      step(a, b, bit'($urandom() % 2), s, bit'($urandom() % 2),
           bit'($urandom() % 2), r0, bit'($urandom() % 2),
           bit'($urandom() % 2), r1, bit'($urandom() % 2),
           ($urandom() % 12) == 0, "R4");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule